// File: doc/BRIEF.md
# Sequencer Conditional Wait Unit

This block is the execution unit for wait and jump commands in a small command-driven power sequencer. A decoded command supplies a 6-bit condition select, a 2-bit trigger type, a 6-bit timeout count and a destination. The destination is either a local sequencer address or an external state ID, chosen by a one-bit space flag. After it accepts the command, the block holds the sequencer until the selected condition meets its trigger test or the timeout runs out. It then reports one of two outcomes: continue with the next command, or jump to the destination.

The condition comes from a fixed map of 64 entries. The entries are GPIO pins, per-rail and global power-good flags, a thermal warning, the interrupt pin, a host control byte, a scratch register and a standby select. Two entries are wired constants. Because constant one tested for LOW can never pass, a wait with that condition always times out, and it serves as an unconditional jump. Timeout time advances only on an external step strobe. Pins that come from outside the clock domain pass through a synchronizer before they are evaluated.

Top module: `seq_wait_unit`

## Requirements
- R1: The condition map, by select code, is as follows. Codes 0..9 are gpio_in[0..9]. Codes 11..14 are rail_pg_in[0..3]. Code 20 is pgood_in, code 21 is twarn_in and code 22 is irq_in. Codes 32..39 are host_ctrl[0..7] and codes 40..47 are scratch0[0..7]. Code 48 is lp_stby_in. Code 62 is constant 0 and code 63 is constant 1. Every other code reads 0.
- R2: The trigger encodings are 0 = level LOW, 1 = level HIGH, 2 = rising edge and 3 = falling edge. A level test passes in any evaluation cycle in which the selected bit has that level.
- R3: An edge test compares the selected bit with its value one cycle earlier. That earlier value is captured when the command is accepted, so a level already present at acceptance is not an edge.
- R4: The timeout counter is loaded from cmd_timeout. It decreases by one only on cycles with step_tick high. It expires in the first evaluation cycle in which it reads zero, so a timeout of 0 expires in the first evaluation cycle.
- R5: If the test passes, done comes with taken_jump=0. If the timeout expires, done comes with taken_jump=1. When both happen in the same cycle, the test wins.
- R6: The first evaluation cycle is the cycle after acceptance. done is a single-cycle pulse in the cycle after the deciding evaluation.
- R7: target and target_ext carry the accepted command's cmd_dest and cmd_ext, and they are valid while done is high.
- R8: When done is high, dest_err is 1 exactly when cmd_ext=0 and cmd_dest <= cmd_pc. It is never 1 for an external destination.
- R9: Pin-sourced conditions (codes 0..22 and 48) pass through two flip-flop stages. host_ctrl and scratch0 are used directly.
- R10: cmd_valid is accepted only while busy is low. A command presented while busy is ignored.
- R11: After reset, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Presents a wait command |
| cmd_cond | input | 6 | Condition select code |
| cmd_trig | input | 2 | Trigger type |
| cmd_timeout | input | TMO_W | Timeout in step ticks |
| cmd_dest | input | AW | Jump destination (address or state ID) |
| cmd_ext | input | 1 | Destination space: 0 local, 1 external state |
| cmd_pc | input | AW | Address of the wait command |
| step_tick | input | 1 | Step-size strobe |
| gpio_in | input | 10 | Asynchronous GPIO levels |
| rail_pg_in | input | 4 | Per-rail power-good flags |
| pgood_in | input | 1 | Global power-good |
| twarn_in | input | 1 | Thermal warning event |
| irq_in | input | 1 | Interrupt pin state |
| lp_stby_in | input | 1 | Low-power standby select |
| host_ctrl | input | 8 | Host-writable control byte |
| scratch0 | input | 8 | Scratch register 0 |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | Single-cycle completion pulse |
| taken_jump | output | 1 | 1: timed out, jump; 0: continue |
| target | output | AW | Destination reported with done |
| target_ext | output | 1 | Destination space reported with done |
| dest_err | output | 1 | Local destination not after the command |

## Verification
If a test passes at the first evaluation, done is due exactly one clock after the accepting edge. A pure timeout of N with step_tick held high gives done N+1 clocks after acceptance. A change on a pin-sourced condition reaches done three edges after it is driven, while a change on host_ctrl or scratch0 reaches done after one edge. The bench drives inputs on the falling edge and counts rising edges until it sees done. It compares that count with the latency computed from these rules, then checks taken_jump, target, target_ext and dest_err in the same sample.

// File: rtl/wait_unit_pkg.sv
package wait_unit_pkg;
  localparam int COND_W    = 6;
  localparam int COND_N    = 1 << COND_W;
  localparam int GPIO_N    = 10;
  localparam int RAIL_N    = 4;
  localparam int BYTE_W    = 8;
  localparam int GPIO_BASE = 0;
  localparam int RAIL_BASE = 11;
  localparam int PGOOD_IDX = 20;
  localparam int TWARN_IDX = 21;
  localparam int IRQ_IDX   = 22;
  localparam int CTRL_BASE = 32;
  localparam int SREG_BASE = 40;
  localparam int LPSB_IDX  = 48;
  localparam int ZERO_IDX  = 62;
  localparam int ONE_IDX   = 63;
  localparam int PIN_N     = GPIO_N + RAIL_N + 4;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wstate_e;
endpackage

// File: rtl/swu_sync.sv
module swu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] src;
      if (g == 0) begin : g_first
        assign src = d;
      end else begin : g_next
        assign src = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= src;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/swu_cond_map.sv
module swu_cond_map
  import wait_unit_pkg::*;
(
  input  logic [GPIO_N-1:0] gpio_s,
  input  logic [RAIL_N-1:0] rail_s,
  input  logic              pgood_s,
  input  logic              twarn_s,
  input  logic              irq_s,
  input  logic              lpsb_s,
  input  logic [BYTE_W-1:0] ctrl,
  input  logic [BYTE_W-1:0] sreg,
  input  logic [COND_W-1:0] sel,
  output logic              cond_bit
);
  logic [COND_N-1:0] vec;

  always_comb begin
    vec                              = '0;
    vec[GPIO_BASE +: GPIO_N]         = gpio_s;
    vec[RAIL_BASE +: RAIL_N]         = rail_s;
    vec[PGOOD_IDX]                   = pgood_s;
    vec[TWARN_IDX]                   = twarn_s;
    vec[IRQ_IDX]                     = irq_s;
    vec[CTRL_BASE +: BYTE_W]         = ctrl;
    vec[SREG_BASE +: BYTE_W]         = sreg;
    vec[LPSB_IDX]                    = lpsb_s;
    vec[ZERO_IDX]                    = 1'b0;
    vec[ONE_IDX]                     = 1'b1;
  end

  assign cond_bit = vec[sel];
endmodule

// File: rtl/swu_ctrl.sv
module swu_ctrl
  import wait_unit_pkg::*;
#(
  parameter int AW    = 8,
  parameter int TMO_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COND_W-1:0] cond_in,
  input  logic [1:0]        trig_in,
  input  logic [TMO_W-1:0]  tmo_in,
  input  logic [AW-1:0]     dest_in,
  input  logic              ext_in,
  input  logic [AW-1:0]     pc_in,
  input  logic              step_tick,
  input  logic              cond_bit,
  output logic [COND_W-1:0] sel,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic [AW-1:0]     target,
  output logic              target_ext,
  output logic              dest_err
);
  wstate_e           state_q, state_d;
  logic [COND_W-1:0] cond_q;
  trig_e             trig_q;
  logic [TMO_W-1:0]  cnt_q, cnt_d;
  logic [AW-1:0]     dest_q;
  logic              ext_q, err_q, prev_q;
  logic              done_q, taken_q, ext_o_q, err_o_q;
  logic [AW-1:0]     tgt_q;

  logic accept, running, met, expired, resolve, cnt_en, prev_en;

  assign accept  = start && (state_q == ST_IDLE);
  assign running = (state_q == ST_RUN);
  assign sel     = running ? cond_q : cond_in;

  always_comb begin
    unique case (trig_q)
      TRIG_LOW:  met = !cond_bit;
      TRIG_HIGH: met = cond_bit;
      TRIG_RISE: met = cond_bit && !prev_q;
      default:   met = !cond_bit && prev_q;
    endcase
  end

  assign expired = (cnt_q == '0);
  assign resolve = running && (met || expired);
  assign prev_en = accept || running;
  assign cnt_en  = accept || (running && !resolve && step_tick);

  always_comb begin
    state_d = state_q;
    if (accept)       state_d = ST_RUN;
    else if (resolve) state_d = ST_IDLE;
    cnt_d = accept ? tmo_in : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      prev_q  <= 1'b0;
      cond_q  <= '0;
      trig_q  <= TRIG_LOW;
      dest_q  <= '0;
      ext_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      tgt_q   <= '0;
      ext_o_q <= 1'b0;
      err_o_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= resolve;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (prev_en) prev_q <= cond_bit;
      if (accept) begin
        cond_q <= cond_in;
        trig_q <= trig_e'(trig_in);
        dest_q <= dest_in;
        ext_q  <= ext_in;
        err_q  <= !ext_in && (dest_in <= pc_in);
      end
      if (resolve) begin
        taken_q <= !met;
        tgt_q   <= dest_q;
        ext_o_q <= ext_q;
        err_o_q <= err_q;
      end
    end
  end

  assign busy       = running;
  assign done       = done_q;
  assign taken      = taken_q;
  assign target     = tgt_q;
  assign target_ext = ext_o_q;
  assign dest_err   = err_o_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_no_early_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_q != '0) |=> !(done_q && taken_q));
  assert_const_one_jumps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cond_q == COND_W'(ONE_IDX) && trig_q == TRIG_LOW) |=> !(done_q && !taken_q));
  assert_ext_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ext_o_q) |-> !err_o_q);
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start) |=> ($stable(cond_q) && $stable(dest_q)));
  assert_accept_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (running && !done_q));
endmodule

// File: rtl/seq_wait_unit.sv
module seq_wait_unit
  import wait_unit_pkg::*;
#(
  parameter int AW          = 8,
  parameter int TMO_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [5:0]        cmd_cond,
  input  logic [1:0]        cmd_trig,
  input  logic [TMO_W-1:0]  cmd_timeout,
  input  logic [AW-1:0]     cmd_dest,
  input  logic              cmd_ext,
  input  logic [AW-1:0]     cmd_pc,
  input  logic              step_tick,
  input  logic [9:0]        gpio_in,
  input  logic [3:0]        rail_pg_in,
  input  logic              pgood_in,
  input  logic              twarn_in,
  input  logic              irq_in,
  input  logic              lp_stby_in,
  input  logic [7:0]        host_ctrl,
  input  logic [7:0]        scratch0,
  output logic              busy,
  output logic              done,
  output logic              taken_jump,
  output logic [AW-1:0]     target,
  output logic              target_ext,
  output logic              dest_err
);
  logic [PIN_N-1:0]  pins_raw, pins_s;
  logic [COND_W-1:0] sel;
  logic              cond_bit;

  assign pins_raw = {lp_stby_in, irq_in, twarn_in, pgood_in, rail_pg_in, gpio_in};

  swu_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  swu_cond_map u_map (
    .gpio_s  (pins_s[GPIO_N-1:0]),
    .rail_s  (pins_s[GPIO_N +: RAIL_N]),
    .pgood_s (pins_s[GPIO_N+RAIL_N]),
    .twarn_s (pins_s[GPIO_N+RAIL_N+1]),
    .irq_s   (pins_s[GPIO_N+RAIL_N+2]),
    .lpsb_s  (pins_s[GPIO_N+RAIL_N+3]),
    .ctrl    (host_ctrl),
    .sreg    (scratch0),
    .sel     (sel),
    .cond_bit(cond_bit)
  );

  swu_ctrl #(.AW(AW), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(cmd_valid),
    .cond_in(cmd_cond), .trig_in(cmd_trig), .tmo_in(cmd_timeout),
    .dest_in(cmd_dest), .ext_in(cmd_ext), .pc_in(cmd_pc),
    .step_tick(step_tick), .cond_bit(cond_bit), .sel(sel),
    .busy(busy), .done(done), .taken(taken_jump), .target(target),
    .target_ext(target_ext), .dest_err(dest_err)
  );
endmodule

// File: tb/tb_seq_wait_unit.sv
module tb_seq_wait_unit;
  localparam int AW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ext = 1'b0, step_tick = 1'b1;
  logic [5:0] cmd_cond = '0, cmd_timeout = '0;
  logic [1:0] cmd_trig = '0;
  logic [AW-1:0] cmd_dest = '0, cmd_pc = '0;
  logic [9:0] gpio_in = '0;
  logic [3:0] rail_pg_in = '0;
  logic pgood_in = 1'b0, twarn_in = 1'b0, irq_in = 1'b0, lp_stby_in = 1'b0;
  logic [7:0] host_ctrl = '0, scratch0 = '0;
  logic busy, done, taken_jump, target_ext, dest_err;
  logic [AW-1:0] target;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  seq_wait_unit #(.AW(AW)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit cond_val(input int c);
    if (c <= 9) return gpio_in[c];
    if (c >= 11 && c <= 14) return rail_pg_in[c-11];
    if (c == 20) return pgood_in;
    if (c == 21) return twarn_in;
    if (c == 22) return irq_in;
    if (c >= 32 && c <= 39) return host_ctrl[c-32];
    if (c >= 40 && c <= 47) return scratch0[c-40];
    if (c == 48) return lp_stby_in;
    if (c == 63) return 1'b1;
    return 1'b0;
  endfunction

  task automatic issue(input int c, input int t, input int tmo, input int dst, input bit ext, input int pc);
    @(negedge clk);
    cmd_cond = 6'(c); cmd_trig = 2'(t); cmd_timeout = 6'(tmo);
    cmd_dest = AW'(dst); cmd_ext = ext; cmd_pc = AW'(pc); cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // counts rising edges from the current falling edge until done is seen
  task automatic count_done(output int lat);
    lat = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (done) return;
    end
    lat = -1;
  endtask

  task automatic expect_run(input string req, input int exp_lat, input bit exp_tk,
                            input int dst, input bit ext, input bit exp_err);
    int lat;
    count_done(lat);
    chk(lat == exp_lat, req, "latency", lat, exp_lat);
    chk(taken_jump == exp_tk, req, "taken_jump", int'(taken_jump), int'(exp_tk));
    chk(target == AW'(dst) && target_ext == ext, "R7", "target", int'(target), dst);
    chk(dest_err == exp_err, "R8", "dest_err", int'(dest_err), int'(exp_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R11", "reset outputs", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R11", "idle after reset", int'({busy, done}), 0);

    // R1 unconditional jump: constant one, LOW, timeout 0
    issue(63, 0, 0, 8'h40, 1'b0, 8'h10);
    expect_run("R1", 1, 1'b1, 8'h40, 1'b0, 1'b0);
    // R5 condition and expiry in same cycle: condition wins
    issue(63, 1, 0, 8'h41, 1'b1, 8'h90);
    expect_run("R5", 1, 1'b0, 8'h41, 1'b1, 1'b0);
    // R1 unused code reads 0 even with all sources high
    gpio_in = '1; rail_pg_in = '1; pgood_in = 1; twarn_in = 1; irq_in = 1; lp_stby_in = 1;
    host_ctrl = '1; scratch0 = '1;
    repeat (4) @(negedge clk);
    issue(10, 1, 2, 8'h30, 1'b0, 8'h30);
    expect_run("R1", 3, 1'b1, 8'h30, 1'b0, 1'b1);
    // R3 level already high is not a rising edge
    issue(2, 2, 3, 8'h50, 1'b0, 8'h20);
    expect_run("R3", 4, 1'b1, 8'h50, 1'b0, 1'b0);
    // R4 no decrement without step ticks
    step_tick = 1'b0;
    issue(62, 1, 5, 8'h60, 1'b1, 8'h00);
    repeat (20) @(negedge clk);
    chk(busy && !done, "R4", "held without ticks", int'({busy, done}), 2);
    // R10 command while busy ignored
    cmd_cond = 6'd63; cmd_trig = 2'd1; cmd_dest = 8'h77; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(!done && busy, "R10", "second command ignored", int'(done), 0);
    step_tick = 1'b1;
    expect_run("R4", 6, 1'b1, 8'h60, 1'b1, 1'b0);
    // R3 R9 rising edge on a synchronized pin
    gpio_in = '0;
    repeat (4) @(negedge clk);
    issue(2, 2, 63, 8'h70, 1'b0, 8'h01);
    repeat (3) @(negedge clk);
    chk(!done && busy, "R3", "no edge yet", int'(done), 0);
    gpio_in[2] = 1'b1;
    expect_run("R9", 3, 1'b0, 8'h70, 1'b0, 1'b0);
    // R2 R9 falling edge on unsynchronized host bit 3 (code 35)
    host_ctrl = 8'h08;
    issue(35, 3, 63, 8'h12, 1'b0, 8'h12);
    repeat (2) @(negedge clk);
    host_ctrl = 8'h00;
    expect_run("R9", 1, 1'b0, 8'h12, 1'b0, 1'b1);
    // R8 local destination just after pc is legal
    issue(62, 1, 1, 8'h13, 1'b0, 8'h12);
    expect_run("R8", 2, 1'b1, 8'h13, 1'b0, 1'b0);

    // constrained random: static inputs, levels and edges
    for (int n = 0; n < 150; n++) begin
      int c, t, tmo, dst, pc, el;
      bit ext, v, m;
      gpio_in = 10'($urandom); rail_pg_in = 4'($urandom);
      pgood_in = 1'($urandom); twarn_in = 1'($urandom); irq_in = 1'($urandom);
      lp_stby_in = 1'($urandom); host_ctrl = 8'($urandom); scratch0 = 8'($urandom);
      repeat (4) @(negedge clk);
      c = int'($urandom % 64); t = int'($urandom % 4); tmo = int'($urandom % 16);
      dst = int'($urandom % 256); pc = int'($urandom % 256); ext = 1'($urandom);
      v = cond_val(c);
      m = (t == 0) ? !v : (t == 1) ? v : 1'b0;
      el = m ? 1 : tmo + 1;
      issue(c, t, tmo, dst, ext, pc);
      count_done(lat);
      chk(lat == el, "R2", "random latency", lat, el);
      chk(taken_jump == !m, "R5", "random taken", int'(taken_jump), int'(!m));
      chk(target == AW'(dst) && target_ext == ext, "R7", "random target", int'(target), dst);
      chk(dest_err == (!ext && dst <= pc), "R8", "random dest_err", int'(dest_err), int'(!ext && dst <= pc));
      @(negedge clk);
      chk(!done, "R6", "done single cycle", int'(done), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule